// File: doc/BRIEF.md
# Memory Range Signature Generator

This engine computes a 128-bit signature over a range of on-chip memory. Software writes a first line address and a last line address; each is a byte address shifted right by four, so one unit is one 16-byte line. Software then sets the run bit in the same write as the last address. The engine fetches every line from the first through the last, one request at a time. It folds each fetched line into a multiple-input shift register (MISR).

When the last line has been absorbed, the run bit drops and the completion flag rises, both in the same cycle. The result appears as four 32-bit read-only words. Software polls the completion flag, reads the four words, and clears the flag through a separate write-one-to-clear register before the next run.

Register reads are combinational on the register address. Writes take effect at the clock edge that samples the write strobe. The memory side is a request/ready handshake with a separate return-valid strobe, and the latency is one cycle or more.

Top module: `mem_sig_gen`

## Requirements
- R1: After reset every register reads zero, no memory request is made and the completion flag is clear.
- R2: Bits 16:0 at offset 0x20 hold the first line address and bits 16:0 at offset 0x24 hold the last line address. Both read back as written. All other bits of these two offsets read zero, except bit 17 of 0x24 described in R3.
- R3: A write to 0x24 with bit 17 set starts a run when the engine is idle. Bit 17 of 0x24 reads 1 while the run is in progress and reads 0 once it ends.
- R4: Bit 2 of the status register at 0xFE0 becomes 1 when a run completes. It is cleared when a run starts and reads 0 while the run is in progress.
- R5: Writing a 1 to bit 2 of 0xFE8 clears the completion flag. A write with bit 2 at 0 leaves the flag unchanged, and 0xFE8 always reads zero.
- R6: A run fetches every line address from the first through the last, both included, in ascending order, and presents each on `mem_addr_o`.
- R7: The MISR starts each run at zero. For each line it becomes `{s[126:0], s[127]^s[125]^s[100]^s[0]} ^ line`.
- R8: The result words at 0x2C, 0x30, 0x34 and 0x38 hold MISR bits 31:0, 63:32, 95:64 and 127:96. They change only when a run completes, in the same cycle as bit 17 falls and the flag rises.
- R9: A request holds its address until `mem_ready_i` accepts it, and no new request is made until `mem_rvalid_i` has returned the line.
- R10: If the last address is below the first, the run completes at the write's clock edge. No memory request is made, the result words become zero, and the run bit never reads 1.
- R11: A write to 0x24 while a run is in progress is ignored. The last address and the run in progress are unchanged.
- R12: Every offset other than 0x20, 0x24, 0x2C to 0x38 and 0xFE0 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| mem_req_o | output | 1 | Line fetch request |
| mem_ready_i | input | 1 | Request accepted |
| mem_addr_o | output | 17 | Line address of the request |
| mem_rvalid_i | input | 1 | Fetched line valid |
| mem_rdata_i | input | 128 | Fetched line |

## Verification
The hardest situation to reach is a second start write that arrives in the middle of a run. The run must be long, the memory must both stall acceptance and delay its return, and the bench must land the write between fetches. The bench gets there with a 16-line run and a memory model that withholds `mem_ready_i` two cycles in three and answers three cycles after acceptance. The conflicting write lands a few cycles into the run, and the bench then checks that the readback, the fetched address log and the final signature all match the original range. The empty-range case is reached by writing a last address below the first right after a non-zero result, so the zeroing of the result words is visible.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int unsigned LINE_W    = 128;
  localparam int unsigned ADDR_W    = 17;
  localparam int unsigned REG_AW    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_WORDS = LINE_W / DATA_W;
  localparam int unsigned BUSY_BIT  = 17;
  localparam int unsigned DONE_BIT  = 2;

  localparam logic [REG_AW-1:0] OFS_FIRST = 12'h020;
  localparam logic [REG_AW-1:0] OFS_LAST  = 12'h024;
  localparam logic [REG_AW-1:0] OFS_SIG0  = 12'h02C;
  localparam logic [REG_AW-1:0] OFS_STAT  = 12'hFE0;
  localparam logic [REG_AW-1:0] OFS_CLR   = 12'hFE8;

  localparam logic [LINE_W-1:0] MISR_TAPS = (LINE_W'(1) << 127) | (LINE_W'(1) << 125)
                                          | (LINE_W'(1) << 100) | LINE_W'(1);

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_WAIT} seq_state_e;
endpackage

// File: rtl/sig_misr.sv
module sig_misr #(
  parameter int unsigned W = sig_pkg::LINE_W,
  parameter logic [W-1:0] TAPS = sig_pkg::MISR_TAPS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         absorb_i,
  input  logic         capture_i,
  input  logic         zero_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] state_q, state_nxt, sig_q;

  assign state_nxt = {state_q[W-2:0], ^(state_q & TAPS)} ^ data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= '0;
    else if (clr_i)     state_q <= '0;
    else if (absorb_i)  state_q <= state_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sig_q <= '0;
    else if (zero_i)     sig_q <= '0;
    else if (capture_i)  sig_q <= state_nxt;
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/sig_seq.sv
module sig_seq import sig_pkg::*; #(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          busy_o,
  output logic          absorb_o,
  output logic          last_line_o,
  output logic          empty_o,
  output logic [AW-1:0] end_line_o
);
  seq_state_e state_q;
  logic [AW-1:0] cur_q, end_q;

  assign empty_o     = go_i && (last_i < first_i);
  assign absorb_o    = (state_q == SEQ_WAIT) && mem_rvalid_i;
  assign last_line_o = absorb_o && (cur_q == end_q);
  assign busy_o      = (state_q != SEQ_IDLE);
  assign mem_req_o   = (state_q == SEQ_REQ);
  assign mem_addr_o  = cur_q;
  assign end_line_o  = end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (go_i && !empty_o) begin
          cur_q   <= first_i;
          end_q   <= last_i;
          state_q <= SEQ_REQ;
        end
        SEQ_REQ: if (mem_ready_i) state_q <= SEQ_WAIT;
        SEQ_WAIT: if (mem_rvalid_i) begin
          if (cur_q == end_q) state_q <= SEQ_IDLE;
          else begin
            cur_q   <= cur_q + AW'(1);
            state_q <= SEQ_REQ;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sig_regs.sv
module sig_regs import sig_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              finish_i,
  input  logic [LINE_W-1:0] sig_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] go_last_o,
  output logic              go_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] first_q, last_q;
  logic              done_q;
  logic              wr_first, wr_last, wr_clr;
  logic [DATA_W-1:0] word [NUM_WORDS];
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:BUSY_BIT+1];

  assign wr_first  = wr_i && (addr_i == OFS_FIRST);
  assign wr_last   = wr_i && (addr_i == OFS_LAST);
  assign wr_clr    = wr_i && (addr_i == OFS_CLR) && wdata_i[DONE_BIT];
  assign go_o      = wr_last && wdata_i[BUSY_BIT] && !busy_i;
  assign go_last_o = wdata_i[ADDR_W-1:0];
  assign first_o   = first_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      if (wr_first)            first_q <= wdata_i[ADDR_W-1:0];
      if (wr_last && !busy_i)  last_q  <= wdata_i[ADDR_W-1:0];
      if (finish_i)            done_q  <= 1'b1;
      else if (go_o || wr_clr) done_q  <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign word[g] = sig_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_FIRST) rdata_o[ADDR_W-1:0] = first_q;
    if (addr_i == OFS_LAST) begin
      rdata_o[ADDR_W-1:0] = last_q;
      rdata_o[BUSY_BIT]   = busy_i;
    end
    if (addr_i == OFS_STAT) rdata_o[DONE_BIT] = done_q;
    for (int i = 0; i < NUM_WORDS; i++)
      if (addr_i == OFS_SIG0 + REG_AW'(4 * i)) rdata_o = word[i];
  end
endmodule

// File: rtl/mem_sig_gen.sv
module mem_sig_gen import sig_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mem_req_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  logic              busy, done, go, absorb, last_line, empty;
  logic [ADDR_W-1:0] first_line, go_last, end_line;
  logic [LINE_W-1:0] sig_q;

  sig_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .finish_i  (last_line || empty),
    .sig_i     (sig_q),
    .first_o   (first_line),
    .go_last_o (go_last),
    .go_o      (go),
    .done_o    (done)
  );

  sig_seq #(.AW(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .go_i         (go),
    .first_i      (first_line),
    .last_i       (go_last),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .busy_o       (busy),
    .absorb_o     (absorb),
    .last_line_o  (last_line),
    .empty_o      (empty),
    .end_line_o   (end_line)
  );

  sig_misr #(.W(LINE_W), .TAPS(MISR_TAPS)) u_misr (
    .clk_i, .rst_ni,
    .clr_i     (go),
    .absorb_i  (absorb),
    .capture_i (last_line),
    .zero_i    (empty),
    .data_i    (mem_rdata_i),
    .sig_o     (sig_q)
  );
endmodule

// File: rtl/sig_gen_chk.sv
module sig_gen_chk import sig_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              done_i,
  input logic              mem_req_i,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [LINE_W-1:0] sig_i,
  input logic [ADDR_W-1:0] end_line_i
);
  AST_BUSY_HIDES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !done_i);  // R4
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ready_i |=> mem_req_i && $stable(mem_addr_i));  // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && mem_ready_i |=> !mem_req_i);  // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_req_i);  // R10
  AST_END_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);  // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(sig_i));  // R8
  AST_ADDR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> mem_addr_i <= end_line_i);  // R6
endmodule

bind mem_sig_gen sig_gen_chk u_sig_gen_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy),
  .done_i      (done),
  .mem_req_i   (mem_req_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_i  (mem_addr_o),
  .sig_i       (sig_q),
  .end_line_i  (end_line)
);

// File: tb/tb_mem_sig_gen.sv
module tb_mem_sig_gen;
  localparam int LAT = 3;
  localparam logic [11:0] A_FIRST = 12'h020, A_LAST = 12'h024, A_SIG0 = 12'h02C,
                          A_STAT = 12'hFE0, A_CLR = 12'hFE8;
  localparam logic [31:0] GO = 32'h0002_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic mem_req, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [16:0] mem_addr;
  logic [127:0] mem_rdata = '0;

  int checks = 0, fails = 0;
  bit stall = 1'b0, finished = 1'b0;
  int cyc = 0, cd = 0, nlog = 0, viol = 0;
  logic [16:0] paddr = '0, prev_addr = '0;
  logic prev_stuck = 1'b0;
  logic [16:0] alog [256];

  always #5 clk = ~clk;

  mem_sig_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(mem_req),
    .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [127:0] line_data(logic [16:0] a);
    logic [31:0] x;
    x = {15'h0, a} * 32'h9E37_79B1;
    return {x, x ^ 32'hA5A5_A5A5, {x[15:0], x[31:16]}, x + 32'h0123_4567};
  endfunction

  function automatic logic [127:0] step(logic [127:0] s, logic [127:0] d);
    return {s[126:0], s[127] ^ s[125] ^ s[100] ^ s[0]} ^ d;
  endfunction

  // memory model: stalls acceptance, fixed return latency, flags protocol errors (R9)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= !stall || (cyc % 3 == 2);
    mem_rvalid <= 1'b0;
    if (prev_stuck && !(mem_req && mem_addr == prev_addr)) viol <= viol + 1;
    prev_stuck <= mem_req && !mem_ready;
    prev_addr  <= mem_addr;
    if (cd != 0) begin
      cd <= cd - 1;
      if (cd == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= line_data(paddr);
      end
    end
    if (mem_req && mem_ready) begin
      if (cd != 0 || mem_rvalid) viol <= viol + 1;
      cd <= LAT;
      paddr <= mem_addr;
      alog[nlog % 256] <= mem_addr;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic read_sig(output logic [127:0] s);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      reg_read(A_SIG0 + 12'(4 * i), w);
      s[32*i +: 32] = w;
    end
  endtask

  task automatic wait_done();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      reg_read(A_STAT, d);
      if (d[2]) break;
      @(negedge clk);
    end
    chk("R4", "completion flag set", {127'b0, d[2]}, 128'd1);
  endtask

  function automatic logic [127:0] expect_sig(logic [16:0] f, logic [16:0] l);
    logic [127:0] s = '0;
    for (int a = int'(f); a <= int'(l); a++) s = step(s, line_data(17'(a)));
    return s;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    logic [127:0] s;
    reg_read(A_FIRST, d); chk("R1", "first after reset", d, 0);
    reg_read(A_LAST, d);  chk("R1", "last after reset", d, 0);
    reg_read(A_STAT, d);  chk("R1", "status after reset", d, 0);
    read_sig(s);          chk("R1", "result after reset", s, 0);
    chk("R1", "no request after reset", mem_req, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_write(A_FIRST, 32'hFFFF_2345);
    reg_read(A_FIRST, d); chk("R2", "first field readback", d, 32'h0001_2345);
    reg_write(A_LAST, 32'hFFFD_0123);
    reg_read(A_LAST, d);  chk("R2", "last field readback", d, 32'h0001_0123);
    reg_read(A_STAT, d);  chk("R2", "no run without bit 17", d, 0);
    chk("R2", "no request without bit 17", mem_req, 0);
    // R12 unmapped offsets
    reg_read(12'h028, d); chk("R12", "offset 0x028", d, 0);
    reg_read(12'h03C, d); chk("R12", "offset 0x03C", d, 0);
    reg_read(12'h000, d); chk("R12", "offset 0x000", d, 0);
    reg_read(12'hFE4, d); chk("R12", "offset 0xFE4", d, 0);
    reg_read(A_CLR, d);   chk("R5", "clear register reads zero", d, 0);
  endtask

  task automatic t_run(logic [16:0] f, logic [16:0] l, bit stl, string tag);
    logic [31:0] d;
    logic [127:0] s;
    int base;
    stall = stl;
    reg_write(A_CLR, 32'h4);
    reg_write(A_FIRST, {15'h0, f});
    base = nlog;
    reg_write(A_LAST, GO | {15'h0, l});
    reg_read(A_LAST, d); chk("R3", {tag, " run bit reads 1"}, d, GO | {15'h0, l});
    reg_read(A_STAT, d); chk("R4", {tag, " flag 0 while running"}, d, 0);
    wait_done();
    reg_read(A_LAST, d); chk("R3", {tag, " run bit cleared"}, d, {15'h0, l});
    chk("R6", {tag, " line count"}, 128'(nlog - base), 128'(int'(l) - int'(f) + 1));
    for (int i = 0; i < nlog - base; i++)
      chk("R6", {tag, " line order"}, alog[(base + i) % 256], 128'(f + 17'(i)));
    read_sig(s);
    chk("R7", {tag, " signature"}, s, expect_sig(f, l));
    chk("R8", {tag, " word 3 position"}, s[127:96], expect_sig(f, l) >> 96);
    chk("R9", {tag, " handshake violations"}, 128'(viol), 0);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    logic [127:0] s;
    int base;
    reg_write(A_CLR, 32'h4);
    reg_write(A_FIRST, 32'h50);
    base = nlog;
    reg_write(A_LAST, GO | 32'h40);
    reg_read(A_STAT, d); chk("R10", "empty range completes at once", d, 32'h4);
    reg_read(A_LAST, d); chk("R10", "run bit never set", d, 32'h40);
    read_sig(s);         chk("R10", "result zero", s, 0);
    repeat (6) @(negedge clk);
    chk("R10", "no fetch", 128'(nlog - base), 0);
  endtask

  task automatic t_busy_write();
    logic [31:0] d;
    logic [127:0] s;
    int base;
    stall = 1'b1;
    reg_write(A_CLR, 32'h4);
    reg_write(A_FIRST, 32'h100);
    base = nlog;
    reg_write(A_LAST, GO | 32'h10F);
    repeat (5) @(negedge clk);
    reg_write(A_LAST, GO | 32'h105);
    reg_read(A_LAST, d); chk("R11", "last unchanged by busy write", d, GO | 32'h10F);
    wait_done();
    chk("R11", "run length unchanged", 128'(nlog - base), 16);
    read_sig(s);
    chk("R11", "signature of original range", s, expect_sig(17'h100, 17'h10F));
  endtask

  task automatic t_clear();
    logic [31:0] d;
    reg_read(A_STAT, d);   chk("R5", "flag set before clear", d, 32'h4);
    reg_write(A_CLR, 32'hFFFF_FFFB);
    reg_read(A_STAT, d);   chk("R5", "bit 2 zero leaves flag", d, 32'h4);
    reg_write(A_CLR, 32'h4);
    reg_read(A_STAT, d);   chk("R5", "flag cleared", d, 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_run(17'h00010, 17'h00010, 1'b0, "single");
    t_run(17'h00200, 17'h00209, 1'b0, "ten");
    t_run(17'h00200, 17'h00209, 1'b1, "ten stalled");  // R7 restart from zero
    t_run(17'h1FFFC, 17'h1FFFF, 1'b1, "top of space");
    t_empty();
    t_busy_write();
    t_clear();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule